// File: doc/BRIEF.md
# Arbitrated Short Bus Reset Requester

This block turns a software request into a short, arbitrated reset of a serial cable bus. Software writes a one to the request bit. If no port is entering suspend or resume at that moment, the block takes the request. Taking it cancels any fair arbitration request that is still outstanding, and it starts a time-out budget.

Once it holds a request, the block waits for a subaction gap and then raises an arbitration request. It keeps that request raised through lost arbitration rounds. When arbitration is won, it gives a short-reset pulse. If the time-out budget runs out first, it gives a long-reset pulse instead. The arbitration signalling on the cable and the reset sequences themselves belong to neighbouring logic.

Top module: `arb_reset_req`

## Requirements
- R1: When the block is idle and no port is busy, a cycle with `wr_en`=1 and `wr_bit`=1 accepts a request. In the next cycle `fair_cancel` is 1 for exactly one cycle, and the request becomes pending.
- R2: A write with `wr_bit`=0 does nothing: no `fair_cancel`, no `arb_req`, and no reset pulse follows.
- R3: A write of one while any bit of `port_busy` is 1 is refused, with no effect on any output.
- R4: After a request is accepted, `arb_req` rises only in the cycle after a cycle in which `gap_seen` was 1 while the request waited for a gap.
- R5: Once raised, `arb_req` stays 1 through every cycle without a win, until a win or a time-out ends the request.
- R6: `arb_won`=1 while `arb_req`=1 produces a one-cycle `short_reset` pulse in the next cycle, and `arb_req` drops in that same cycle.
- R7: The time-out is loaded from `tout_limit` at acceptance. Suppose no win comes. If the request was accepted at clock edge k, `long_reset` is 1 for one cycle after edge k+`tout_limit`+1, and `arb_req` is 0 from then on.
- R8: `req_rdata`, the readback of the request bit, is always 0.
- R9: A write of one while a request is pending has no effect. It produces no second `fair_cancel`, and it does not restart the time-out.
- R10: When `arb_won` arrives in the same cycle the time-out expires, the win takes priority: `short_reset` pulses and `long_reset` stays 0.
- R11: `arb_won` while the block is still waiting for a gap (`arb_req`=0) is ignored.
- R12: `short_reset`, `long_reset` and `fair_cancel` are single-cycle pulses. `short_reset` and `long_reset` are never 1 together.
- R13: After synchronous reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the request bit |
| wr_bit | input | 1 | Data written to the request bit |
| port_busy | input | NPORTS | Per-port flag: suspend or resume entry in progress |
| gap_seen | input | 1 | Pulse: a subaction gap was detected |
| arb_won | input | 1 | Pulse: arbitration for the request was won |
| tout_limit | input | CNT_W | Time-out budget in cycles, sampled at acceptance |
| arb_req | output | 1 | Arbitration request for the short reset |
| fair_cancel | output | 1 | Pulse: abandon the outstanding fair request |
| short_reset | output | 1 | Pulse: issue the short bus reset |
| long_reset | output | 1 | Pulse: time-out fallback to a long bus reset |
| req_rdata | output | 1 | Readback of the request bit |

## Verification
The hardest case to reach is a win that lands in exactly the cycle in which the time-out budget reaches zero. Only that coincidence separates the win-over-time-out priority from the reverse ordering. The bench drives a short budget, supplies a gap at once, and then asserts `arb_won` precisely in the cycle its own model predicts as the expiry cycle. The random phase mixes small budgets (including zero) with sparse wins and gaps so that near-coincidences also occur. Repeated writes during a pending request are also targeted, to show that they do not restart the time-out.

// File: rtl/arb_reset_pkg.sv
package arb_reset_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_GAP = 2'd1,
        ST_ARB      = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic fair_cancel;
        logic short_reset;
        logic long_reset;
    } arb_pulse_t;

    function automatic logic st_pending(arb_state_e s);
        return (s == ST_WAIT_GAP) || (s == ST_ARB);
    endfunction

endpackage

// File: rtl/arb_reset_gate.sv
module arb_reset_gate #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [NPORTS-1:0] port_busy,
    input  logic              idle,
    output logic              accept
);
    logic [NPORTS:0] busy_chain;
    logic            any_busy;

    assign busy_chain[0] = 1'b0;
    for (genvar g = 0; g < NPORTS; g++) begin : g_busy
        assign busy_chain[g+1] = busy_chain[g] | port_busy[g];
    end
    assign any_busy = busy_chain[NPORTS];

    assign accept = wr_en & wr_bit & ~any_busy & idle;

    assert_refuse_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (port_busy != '0) |-> !accept);

    assert_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_bit |-> !accept);

endmodule

// File: rtl/arb_reset_timer.sv
module arb_reset_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic             running;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (load) begin
            running <= 1'b1;
            cnt     <= limit;
        end else if (clear) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (running && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = running && (cnt == '0);

    assert_no_reload_R9: assert property (@(posedge clk) disable iff (rst)
        load |-> !running);

    assert_expire_once_R12: assert property (@(posedge clk) disable iff (rst)
        (expire && !load) |=> !expire);

endmodule

// File: rtl/arb_reset_fsm.sv
module arb_reset_fsm
    import arb_reset_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic gap_seen,
    input  logic arb_won,
    input  logic expire,
    output logic idle,
    output logic clr_timer,
    output logic arb_req,
    output logic fair_cancel,
    output logic short_reset,
    output logic long_reset
);
    arb_state_e state, state_nx;
    arb_pulse_t pulse_q, pulse_nx;
    logic       won_now;

    assign won_now   = (state == ST_ARB) && arb_won;
    assign idle      = !st_pending(state);
    assign clr_timer = won_now || expire;

    always_comb begin
        state_nx = state;
        pulse_nx = '0;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx             = ST_WAIT_GAP;
                    pulse_nx.fair_cancel = 1'b1;
                end
            end
            ST_WAIT_GAP, ST_ARB: begin
                if (won_now) begin
                    state_nx             = ST_IDLE;
                    pulse_nx.short_reset = 1'b1;
                end else if (expire) begin
                    state_nx            = ST_IDLE;
                    pulse_nx.long_reset = 1'b1;
                end else if (state == ST_WAIT_GAP && gap_seen) begin
                    state_nx = ST_ARB;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pulse_q <= '0;
        end else begin
            state   <= state_nx;
            pulse_q <= pulse_nx;
        end
    end

    assign arb_req     = (state == ST_ARB);
    assign fair_cancel = pulse_q.fair_cancel;
    assign short_reset = pulse_q.short_reset;
    assign long_reset  = pulse_q.long_reset;

    assert_gap_first_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(arb_req) |-> $past(gap_seen));

    assert_hold_req_R5: assert property (@(posedge clk) disable iff (rst)
        (arb_req && !arb_won && !expire) |=> arb_req);

    assert_win_short_R6: assert property (@(posedge clk) disable iff (rst)
        (arb_req && arb_won) |=> (short_reset && !arb_req));

    assert_win_priority_R10: assert property (@(posedge clk) disable iff (rst)
        (arb_req && arb_won && expire) |=> !long_reset);

    assert_early_win_R11: assert property (@(posedge clk) disable iff (rst)
        (!arb_req && !expire) |=> !short_reset);

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({short_reset, long_reset}));

    assert_cancel_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        fair_cancel |=> !fair_cancel);

endmodule

// File: rtl/arb_reset_req.sv
module arb_reset_req #(
    parameter int NPORTS = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic [NPORTS-1:0] port_busy,
    input  logic              gap_seen,
    input  logic              arb_won,
    input  logic [CNT_W-1:0]  tout_limit,
    output logic              arb_req,
    output logic              fair_cancel,
    output logic              short_reset,
    output logic              long_reset,
    output logic              req_rdata
);
    logic idle;
    logic accept;
    logic expire;
    logic clr_timer;

    arb_reset_gate #(.NPORTS(NPORTS)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit),
        .port_busy (port_busy),
        .idle      (idle),
        .accept    (accept)
    );

    arb_reset_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .clear  (clr_timer),
        .limit  (tout_limit),
        .expire (expire)
    );

    arb_reset_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .gap_seen    (gap_seen),
        .arb_won     (arb_won),
        .expire      (expire),
        .idle        (idle),
        .clr_timer   (clr_timer),
        .arb_req     (arb_req),
        .fair_cancel (fair_cancel),
        .short_reset (short_reset),
        .long_reset  (long_reset)
    );

    assign req_rdata = 1'b0;

    assert_long_drops_R7: assert property (@(posedge clk) disable iff (rst)
        long_reset |-> !arb_req);

endmodule

// File: tb/test_arb_reset_req.sv
module test_arb_reset_req;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0, wr_bit = 1'b0, gap_seen = 1'b0, arb_won = 1'b0;
    logic [NP-1:0] port_busy = '0;
    logic [CW-1:0] tout_limit = '0;
    logic          arb_req, fair_cancel, short_reset, long_reset, req_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    string cur_tag = "R13";

    // reference model state: 0 idle, 1 waiting for gap, 2 arbitrating
    int          m_st = 0;
    int          m_cnt = 0;
    logic        e_cancel = 0, e_short = 0, e_long = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arb_reset_req #(.NPORTS(NP), .CNT_W(CW)) i_arb_reset_req (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit),
        .port_busy(port_busy), .gap_seen(gap_seen), .arb_won(arb_won),
        .tout_limit(tout_limit), .arb_req(arb_req), .fair_cancel(fair_cancel),
        .short_reset(short_reset), .long_reset(long_reset), .req_rdata(req_rdata)
    );

    task automatic check(string tag, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(cur_tag, "arb_req (R5)", arb_req, logic'(m_st == 2));
        check(cur_tag, "fair_cancel (R1)", fair_cancel, e_cancel);
        check(cur_tag, "short_reset (R6)", short_reset, e_short);
        check(cur_tag, "long_reset (R7)", long_reset, e_long);
        check(cur_tag, "req_rdata (R8)", req_rdata, 1'b0);
        check(cur_tag, "exclusive pulses (R12)", short_reset & long_reset, 1'b0);
    endtask

    task automatic step(logic w, logic d, logic [NP-1:0] busy, logic gap, logic won);
        int  n_st, n_cnt;
        logic n_c, n_s, n_l;
        @(negedge clk);
        compare_all();
        wr_en = w; wr_bit = d; port_busy = busy; gap_seen = gap; arb_won = won;
        n_st = m_st; n_cnt = m_cnt; n_c = 0; n_s = 0; n_l = 0;
        if (m_st == 0) begin
            if (w && d && busy == '0) begin
                n_st = 1; n_cnt = int'(tout_limit); n_c = 1;
            end
        end else if (m_st == 2 && won) begin
            n_st = 0; n_s = 1;
        end else if (m_cnt == 0) begin
            n_st = 0; n_l = 1;
        end else begin
            n_cnt = m_cnt - 1;
            if (m_st == 1 && gap) n_st = 2;
        end
        @(posedge clk);
        #1;
        m_st = n_st; m_cnt = n_cnt; e_cancel = n_c; e_short = n_s; e_long = n_l;
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        cur_tag = "R13";
        idle_cycles(2);

        // R1/R7 accept, no gap, time-out fires
        cur_tag = "R7";
        tout_limit = 16'd4;
        step(1, 1, '0, 0, 0);
        idle_cycles(8);

        // R2 write of zero ignored
        cur_tag = "R2";
        step(1, 0, '0, 0, 0);
        idle_cycles(4);

        // R3 refused while a single port is busy
        cur_tag = "R3";
        step(1, 1, 4'b0100, 0, 0);
        step(1, 1, 4'b1000, 1, 0);
        idle_cycles(4);

        // R4 no arb_req without a gap, then R6 win
        cur_tag = "R4";
        tout_limit = 16'd20;
        step(1, 1, '0, 0, 0);
        idle_cycles(4);
        step(0, 0, '0, 1, 0);
        cur_tag = "R5";
        idle_cycles(5);
        cur_tag = "R6";
        step(0, 0, '0, 0, 1);
        idle_cycles(3);

        // R11 win while waiting for a gap is ignored
        cur_tag = "R11";
        step(1, 1, '0, 0, 0);
        step(0, 0, '0, 0, 1);
        step(0, 0, '0, 0, 1);
        step(0, 0, '0, 1, 0);
        step(0, 0, '0, 0, 1);
        idle_cycles(3);

        // R9 repeated write while pending does not restart
        cur_tag = "R9";
        tout_limit = 16'd5;
        step(1, 1, '0, 0, 0);
        step(0, 0, '0, 0, 0);
        tout_limit = 16'd30;
        step(1, 1, '0, 0, 0);
        step(1, 1, '0, 1, 0);
        idle_cycles(6);

        // R10 win on the exact expiry cycle
        cur_tag = "R10";
        tout_limit = 16'd3;
        step(1, 1, '0, 0, 0);
        step(0, 0, '0, 1, 0);
        while (!(m_st == 2 && m_cnt == 0)) step(0, 0, '0, 0, 0);
        step(0, 0, '0, 0, 1);
        idle_cycles(3);

        // R7 zero budget
        cur_tag = "R7";
        tout_limit = 16'd0;
        step(1, 1, '0, 1, 0);
        idle_cycles(3);

        // random phase
        cur_tag = "R12";
        for (int i = 0; i < 4000; i++) begin
            logic          w, d, g, wn;
            logic [NP-1:0] b;
            if (m_st == 0 && ($urandom % 8) == 0) tout_limit = CW'($urandom % 12);
            w  = ($urandom % 6) == 0;
            d  = ($urandom % 4) != 0;
            b  = (($urandom % 5) == 0) ? NP'($urandom) : '0;
            g  = ($urandom % 4) == 0;
            wn = ($urandom % 7) == 0;
            step(w, d, b, g, wn);
        end
        idle_cycles(2);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule